// File: doc/BRIEF.md
# Cascaded Local Interrupt Controller

This block collects level-sensitive interrupt lines into two local groups of eight and one shared group of eight mappable lines. Each local group has its own enable mask. The mappable lines form a single status vector that two separate mask registers filter. Each filtered result drives one reserved cascade position in one of the local groups. Both local groups then produce a level request towards the processor, and each group also presents a combinational "who is highest" answer. An interrupt handler reads that answer to find which line to service, whether the line is local or reached through the cascade.

A small register port gives read access to both local status vectors and to the mappable status vector. It also gives read and write access to the four masks. When the handler writes a mapped mask, the hardware keeps the matching cascade enable in step with it. A non-zero mapped mask therefore always opens its path into the local group, and a mask of zero closes it.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Local status of group 0 takes the external lines on every bit except bit 3, and group 1 does the same except bit 5. The cascade bit (bit 3 in group 0, bit 5 in group 1) reads as the OR of the mappable status ANDed with that group's mapped mask. The external line at the cascade position is ignored.
- R2: A group's pending set is its status AND its local mask. The level outputs `lvl0_irq_o` and `lvl1_irq_o` equal the OR of their group's pending set, one clock edge later.
- R3: Bit 7 of a pending set has the highest priority and bit 0 the lowest. The reported index is the position of the highest set bit.
- R4: When the selected set is all zero, the source reports valid = 0, group = 0 and index = 0.
- R5: Synchronous reset clears all four masks, both level outputs and the read data. After reset no source is valid, whatever the inputs are.
- R6: When a group's cascade bit is pending, its source is taken from the mapped pending set, and the group code is 2 (reached through mask 0) or 3 (reached through mask 1). Otherwise the group code is 0 for local group 0 and 1 for local group 1.
- R7: The two mapped masks filter the same mappable vector independently of each other.
- R8: The register addresses are: 0 local status 0, 1 local status 1, 2 local mask 0, 3 local mask 1, 4 mapped mask 0, 5 mapped mask 1, 6 mappable status. Address 7 reads zero. Read data is registered and shows the addressed register one edge after the address is presented.
- R9: A write to mapped mask 0 sets local mask 0 bit 3 to the OR of the written value. A write to mapped mask 1 does the same for local mask 1 bit 5.
- R10: Writes take effect on the next clock edge. Writes to addresses 0, 1, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line0_i | input | 8 | Level interrupt lines of local group 0 |
| line1_i | input | 8 | Level interrupt lines of local group 1 |
| map_i | input | 8 | Shared mappable interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| lvl0_irq_o | output | 1 | Registered level request of local group 0 |
| lvl1_irq_o | output | 1 | Registered level request of local group 1 |
| src0_valid | output | 1 | Group 0 has a source to report |
| src0_grp | output | 2 | Group code of the group 0 source |
| src0_idx | output | 3 | Line index of the group 0 source |
| src1_valid | output | 1 | Group 1 has a source to report |
| src1_grp | output | 2 | Group code of the group 1 source |
| src1_idx | output | 3 | Line index of the group 1 source |

## Verification
A mapped mask write and a mapped line that is already high can act in the same cycle. The write then opens the cascade enable and the mapped pending path at one edge, and the level output must follow exactly one edge later. The bench provokes this by raising a mappable line while every mask is closed and then writing the mapped mask. At the first falling edge after the write it expects the source to be valid through the cascade while the level output is still low, and at the next it expects the level output high. Sweeps over every line and mask value compare each source and level output with an arithmetic model of the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    GRP_LOC0 = 2'd0,
    GRP_LOC1 = 2'd1,
    GRP_MAP0 = 2'd2,
    GRP_MAP1 = 2'd3
  } grp_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_LSTAT0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LSTAT1 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LMASK0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LMASK1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MMASK0 = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MMASK1 = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_MSTAT  = 3'd6;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  // ascending scan: the last hit is the highest set bit
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int             W      = 8,
  parameter int             CASC   = 3,
  parameter irq_pkg::grp_e  LOC_ID = irq_pkg::GRP_LOC0,
  parameter irq_pkg::grp_e  MAP_ID = irq_pkg::GRP_MAP0,
  localparam int            IW     = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  lines,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  mmask,
  input  logic [W-1:0]  mstat,
  output logic [W-1:0]  stat,
  output logic          pend_any,
  output logic          src_valid,
  output logic [1:0]    src_grp,
  output logic [IW-1:0] src_idx
);
  localparam logic [W-1:0] CMASK = W'(1) << CASC;

  logic [W-1:0]  mpend;
  logic [W-1:0]  pend;
  logic [W-1:0]  sel;
  logic          use_map;
  logic          enc_any;
  logic [IW-1:0] enc_idx;

  assign mpend    = mstat & mmask;
  assign stat     = (lines & ~CMASK) | ((|mpend) ? CMASK : '0);
  assign pend     = stat & mask;
  assign pend_any = |pend;
  assign use_map  = pend[CASC];
  assign sel      = use_map ? mpend : pend;

  irq_prio_enc #(.W(W)) u_enc (
    .vec (sel),
    .any (enc_any),
    .idx (enc_idx)
  );

  always_comb begin
    src_valid = enc_any;
    src_grp   = 2'd0;
    src_idx   = '0;
    if (enc_any) begin
      src_grp = use_map ? MAP_ID : LOC_ID;
      src_idx = enc_idx;
    end
  end

  // R3: no set bit above the reported index
  a_r3_highest_bit: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> ((sel >> src_idx) == W'(1)));
  // R6: a pending cascade bit redirects to the mapped set
  a_r6_cascade_redirect: assert property (@(posedge clk) disable iff (rst)
    pend[CASC] |-> (src_valid && src_grp == MAP_ID && mpend[src_idx]));
  // R4: an empty set reports nothing
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
    !pend_any |-> (!src_valid && src_grp == 2'd0 && src_idx == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int W     = 8,
  parameter int CASC0 = 3,
  parameter int CASC1 = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [irq_pkg::ADDR_W-1:0] addr,
  input  logic [W-1:0]               wdata,
  input  logic [W-1:0]               stat0,
  input  logic [W-1:0]               stat1,
  input  logic [W-1:0]               mstat,
  output logic [W-1:0]               lmask0,
  output logic [W-1:0]               lmask1,
  output logic [W-1:0]               mmask0,
  output logic [W-1:0]               mmask1,
  output logic [W-1:0]               rdata
);
  import irq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      lmask0 <= '0;
      lmask1 <= '0;
      mmask0 <= '0;
      mmask1 <= '0;
    end else if (wr) begin
      case (addr)
        ADR_LMASK0: lmask0 <= wdata;
        ADR_LMASK1: lmask1 <= wdata;
        ADR_MMASK0: begin
          mmask0        <= wdata;
          lmask0[CASC0] <= |wdata;
        end
        ADR_MMASK1: begin
          mmask1        <= wdata;
          lmask1[CASC1] <= |wdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADR_LSTAT0: rdata <= stat0;
        ADR_LSTAT1: rdata <= stat1;
        ADR_LMASK0: rdata <= lmask0;
        ADR_LMASK1: rdata <= lmask1;
        ADR_MMASK0: rdata <= mmask0;
        ADR_MMASK1: rdata <= mmask1;
        ADR_MSTAT:  rdata <= mstat;
        default:    rdata <= '0;
      endcase
    end
  end

  // R5: masks are clear in the first cycle after reset
  a_r5_masks_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lmask0 == '0 && lmask1 == '0 && mmask0 == '0 && mmask1 == '0));
  // R9: cascade enables follow mapped mask writes
  a_r9_casc0_follows: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_MMASK0) |=> (lmask0[CASC0] == (|mmask0)));
  a_r9_casc1_follows: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADR_MMASK1) |=> (lmask1[CASC1] == (|mmask1)));
  // R10: writes to read-only addresses leave every mask unchanged
  a_r10_ro_write: assert property (@(posedge clk) disable iff (rst)
    (wr && (addr == ADR_LSTAT0 || addr == ADR_LSTAT1 || addr == ADR_MSTAT))
      |=> ($stable(lmask0) && $stable(lmask1) && $stable(mmask0) && $stable(mmask1)));
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int W     = 8,
  parameter int CASC0 = 3,
  parameter int CASC1 = 5,
  localparam int IW   = $clog2(W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [W-1:0]               line0_i,
  input  logic [W-1:0]               line1_i,
  input  logic [W-1:0]               map_i,
  input  logic                       reg_wr,
  input  logic [irq_pkg::ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]               reg_wdata,
  output logic [W-1:0]               reg_rdata,
  output logic                       lvl0_irq_o,
  output logic                       lvl1_irq_o,
  output logic                       src0_valid,
  output logic [1:0]                 src0_grp,
  output logic [IW-1:0]              src0_idx,
  output logic                       src1_valid,
  output logic [1:0]                 src1_grp,
  output logic [IW-1:0]              src1_idx
);
  import irq_pkg::*;

  localparam int NG = 2;

  logic [W-1:0]  lines_a [NG];
  logic [W-1:0]  lmask_a [NG];
  logic [W-1:0]  mmask_a [NG];
  logic [W-1:0]  stat_a  [NG];
  logic [NG-1:0] pend_any;
  logic [NG-1:0] valid_a;
  logic [1:0]    grp_a   [NG];
  logic [IW-1:0] idx_a   [NG];
  logic [NG-1:0] lvl_q;

  assign lines_a[0] = line0_i;
  assign lines_a[1] = line1_i;

  irq_regs #(.W(W), .CASC0(CASC0), .CASC1(CASC1)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .stat0  (stat_a[0]),
    .stat1  (stat_a[1]),
    .mstat  (map_i),
    .lmask0 (lmask_a[0]),
    .lmask1 (lmask_a[1]),
    .mmask0 (mmask_a[0]),
    .mmask1 (mmask_a[1]),
    .rdata  (reg_rdata)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int   CPOS = (g == 0) ? CASC0 : CASC1;
    localparam grp_e LID  = (g == 0) ? GRP_LOC0 : GRP_LOC1;
    localparam grp_e MID  = (g == 0) ? GRP_MAP0 : GRP_MAP1;

    irq_group #(.W(W), .CASC(CPOS), .LOC_ID(LID), .MAP_ID(MID)) u_group (
      .clk       (clk),
      .rst       (rst),
      .lines     (lines_a[g]),
      .mask      (lmask_a[g]),
      .mmask     (mmask_a[g]),
      .mstat     (map_i),
      .stat      (stat_a[g]),
      .pend_any  (pend_any[g]),
      .src_valid (valid_a[g]),
      .src_grp   (grp_a[g]),
      .src_idx   (idx_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= pend_any;
  end

  assign lvl0_irq_o = lvl_q[0];
  assign lvl1_irq_o = lvl_q[1];
  assign src0_valid = valid_a[0];
  assign src0_grp   = grp_a[0];
  assign src0_idx   = idx_a[0];
  assign src1_valid = valid_a[1];
  assign src1_grp   = grp_a[1];
  assign src1_idx   = idx_a[1];

  // R2: a level request appears one edge after a valid source
  a_r2_level_follows0: assert property (@(posedge clk) disable iff (rst)
    src0_valid |=> lvl0_irq_o);
  a_r2_level_follows1: assert property (@(posedge clk) disable iff (rst)
    src1_valid |=> lvl1_irq_o);
  // R7: each group reports only its own mapped path
  a_r7_own_map_path: assert property (@(posedge clk) disable iff (rst)
    (src0_grp != GRP_LOC1 && src0_grp != GRP_MAP1 &&
     src1_grp != GRP_MAP0 && (!src1_valid || src1_grp != GRP_LOC0)));
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] line0_i = '0, line1_i = '0, map_i = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       lvl0_irq_o, lvl1_irq_o;
  logic       src0_valid, src1_valid;
  logic [1:0] src0_grp, src1_grp;
  logic [2:0] src0_idx, src1_idx;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;
  logic [7:0] sh_lm0 = '0, sh_lm1 = '0, sh_mm0 = '0, sh_mm1 = '0;

  always #10 clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .line0_i(line0_i), .line1_i(line1_i), .map_i(map_i),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl0_irq_o(lvl0_irq_o), .lvl1_irq_o(lvl1_irq_o),
    .src0_valid(src0_valid), .src0_grp(src0_grp), .src0_idx(src0_idx),
    .src1_valid(src1_valid), .src1_grp(src1_grp), .src1_idx(src1_idx)
  );

  function automatic logic [7:0] st_m(input logic [7:0] ln, mm, mp, input int casc);
    logic [7:0] s;
    s = ln;
    s[casc] = |(mp & mm);
    return s;
  endfunction

  function automatic logic [5:0] src_m(input logic [7:0] ln, lm, mm, mp,
                                       input int casc, input logic [1:0] gl, gm);
    logic [7:0] pd, v;
    logic [1:0] g;
    logic [2:0] ix;
    pd = st_m(ln, mm, mp, casc) & lm;
    if (pd[casc]) begin v = mp & mm; g = gm; end
    else begin v = pd; g = gl; end
    ix = 3'd0;
    for (int i = 0; i < 8; i++) if (v[i]) ix = 3'(i);
    if (v == 8'd0) return 6'd0;
    return {1'b1, g, ix};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [7:0] act, exp_v);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    case (a)
      3'd2: sh_lm0 = d;
      3'd3: sh_lm1 = d;
      3'd4: begin sh_mm0 = d; sh_lm0[3] = |d; end
      3'd5: begin sh_mm1 = d; sh_lm1[5] = |d; end
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp_v, input string req);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(reg_rdata == exp_v, req, reg_rdata, exp_v);
  endtask

  // sources now, level outputs after the next edge
  task automatic vec_chk(input string req);
    logic [5:0] e0, e1;
    logic p0, p1;
    #1;
    e0 = src_m(line0_i, sh_lm0, sh_mm0, map_i, 3, 2'd0, 2'd2);
    e1 = src_m(line1_i, sh_lm1, sh_mm1, map_i, 5, 2'd1, 2'd3);
    p0 = |(st_m(line0_i, sh_mm0, map_i, 3) & sh_lm0);
    p1 = |(st_m(line1_i, sh_mm1, map_i, 5) & sh_lm1);
    chk({src0_valid, src0_grp, src0_idx} == e0, {req, " src0"},
        {2'b0, src0_valid, src0_grp, src0_idx}, {2'b0, e0});
    chk({src1_valid, src1_grp, src1_idx} == e1, {req, " src1"},
        {2'b0, src1_valid, src1_grp, src1_idx}, {2'b0, e1});
    @(posedge clk);
    @(negedge clk);
    chk({lvl1_irq_o, lvl0_irq_o} == {p1, p0}, "R2 level outputs",
        {6'b0, lvl1_irq_o, lvl0_irq_o}, {6'b0, p1, p0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    line0_i = 8'hFF; line1_i = 8'hFF; map_i = 8'hFF;
    rst = 1'b0;
    #1;
    // R5: reset state
    chk(!src0_valid && !src1_valid, "R5 no source after reset",
        {6'b0, src1_valid, src0_valid}, 8'h00);
    chk(!lvl0_irq_o && !lvl1_irq_o && reg_rdata == 8'h00, "R5 outputs low after reset",
        {reg_rdata[5:0], lvl1_irq_o, lvl0_irq_o}, 8'h00);
    for (int a = 2; a < 6; a++) rd_chk(3'(a), 8'h00, "R5 R8 mask clear after reset");

    // R1 / R8: status readback, cascade bits closed
    line1_i = 8'h00;
    rd_chk(3'd0, 8'hF7, "R1 R8 local status 0");
    rd_chk(3'd1, 8'h00, "R1 R8 local status 1");
    rd_chk(3'd6, 8'hFF, "R8 mappable status");
    rd_chk(3'd7, 8'h00, "R8 unused address");

    // R10: writes to read-only addresses have no effect
    wr_reg(3'd0, 8'h55);
    wr_reg(3'd1, 8'h55);
    wr_reg(3'd6, 8'h55);
    wr_reg(3'd7, 8'h55);
    for (int a = 2; a < 6; a++) rd_chk(3'(a), 8'h00, "R10 mask unchanged");
    rd_chk(3'd0, 8'hF7, "R10 status unchanged");

    // R2 R3 R4: local priority sweep, cascades closed
    wr_reg(3'd2, 8'hF7);
    wr_reg(3'd3, 8'hDF);
    for (int v = 0; v < 256; v++) begin
      line0_i = 8'(v); line1_i = ~8'(v); map_i = 8'(v);
      vec_chk("R3 R4 local sweep");
    end

    // R9: cascade enable tracks mapped mask writes
    wr_reg(3'd4, 8'h81);
    rd_chk(3'd2, 8'hFF, "R9 cascade 0 opened");
    wr_reg(3'd4, 8'h00);
    rd_chk(3'd2, 8'hF7, "R9 cascade 0 closed");
    wr_reg(3'd5, 8'h02);
    rd_chk(3'd3, 8'hFF, "R9 cascade 1 opened");
    rd_chk(3'd5, 8'h02, "R8 mapped mask 1 readback");

    // R1 R6 R7: mapped sweeps through both cascades
    line0_i = 8'h15; line1_i = 8'h0C;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m0;
      m0 = (k == 0) ? 8'hFF : (k == 1) ? 8'h81 : 8'h3C;
      wr_reg(3'd4, m0);
      wr_reg(3'd5, ~m0);
      wr_reg(3'd2, 8'hFF);
      wr_reg(3'd3, 8'hFF);
      for (int v = 0; v < 256; v++) begin
        map_i = 8'(v);
        vec_chk("R6 R7 mapped sweep");
      end
      map_i = 8'h99;
      rd_chk(3'd0, st_m(line0_i, sh_mm0, map_i, 3), "R1 cascade status 0");
      rd_chk(3'd1, st_m(line1_i, sh_mm1, map_i, 5), "R1 cascade status 1");
    end

    // R3 R10: local mask sweep with all lines high
    line0_i = 8'hFF; map_i = 8'hFF;
    wr_reg(3'd4, 8'h24);
    for (int m = 0; m < 256; m++) begin
      wr_reg(3'd2, 8'(m));
      vec_chk("R3 R10 mask sweep");
    end

    // R2 R9 collision: mapped mask write while a mapped line is high
    wr_reg(3'd5, 8'h00);
    wr_reg(3'd3, 8'h00);
    line1_i = 8'h00; map_i = 8'h40;
    @(negedge clk);
    chk(!lvl1_irq_o && !src1_valid, "R2 closed before write",
        {6'b0, lvl1_irq_o, src1_valid}, 8'h00);
    wr_reg(3'd5, 8'h40);
    #1;
    chk({src1_valid, src1_grp, src1_idx} == {1'b1, 2'd3, 3'd6}, "R6 R9 source on write edge",
        {2'b0, src1_valid, src1_grp, src1_idx}, {2'b0, 1'b1, 2'd3, 3'd6});
    chk(!lvl1_irq_o, "R2 level not yet up", {7'b0, lvl1_irq_o}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk(lvl1_irq_o, "R2 level one edge later", {7'b0, lvl1_irq_o}, 8'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule